// File: doc/BRIEF.md
# Watchdog Timer with Recovery Switch

This block supervises a clock generator's configuration. Once enabled with a non-zero timeout, it counts down in steps of either 150 ms (coarse scale) or 15 ms (fine scale). The steps come from a millisecond tick that a reference-clock divider produces. Software keeps the timer alive by pulsing `kick` or by writing any configuration register, which raises `cfg_write`. Either one reloads the count from the programmed 5-bit timeout and restarts the step timing.

If the count runs out, the block does three things. It sets a sticky expiry flag. It emits a one-cycle `rec_select` strobe that tells the clock generator to fall back to the recovery divider values, which it latches onto `rec_n_out` and `rec_m_out`. If reset is enabled, it also drives `sys_rst_pulse` for a fixed number of reference cycles. The expiry flag is cleared only by a `status_clr` pulse.

The controller is a five-state machine:
- `ST_IDLE`: the timer is disabled, or the timeout field is zero.
- `ST_ARMED`: counting down.
- `ST_FIRE`: a single strobe cycle.
- `ST_PULSE`: the reset pulse.
- `ST_EXPIRED`: expired and waiting to be re-armed.

Its transitions are:
- IDLE→ARMED, taken when the timer becomes active.
- ARMED→ARMED with a reload, on a kick or write.
- ARMED→FIRE, taken on the last step.
- FIRE→PULSE or FIRE→EXPIRED, chosen by the reset enable.
- PULSE→EXPIRED, taken when the pulse count ends.
- EXPIRED→ARMED, on a kick or write.
- ARMED/EXPIRED→IDLE, taken on disable.

Top module: `wdt_recovery_ctrl`

## Requirements
- R1: After reset, `wd_status`, `sys_rst_pulse`, `rec_select`, `rec_n_out` and `rec_m_out` are all 0.
- R2: With `wd_coarse`=1, expiry (`rec_select` high) occurs exactly T×150×CLK_PER_MS clock edges after the edge on which the timer was loaded, where T is `wd_timeout`.
- R3: With `wd_coarse`=0, each step is 15 ms, so expiry occurs T×15×CLK_PER_MS edges after the load edge.
- R4: While `wd_enable`=0, or while `wd_timeout`=0, the timer never expires: there is no strobe and `wd_status` stays unchanged.
- R5: A `kick` or `cfg_write` pulse in the armed state reloads the full timeout, so expiry moves to T×step edges after that pulse's edge.
- R6: `wd_status` is set on expiry and stays set through reloads. Only a `status_clr` pulse clears it. If a clear and an expiry land on the same edge, the flag ends up set.
- R7: If `rst_enable` is 1 when the strobe occurs, `sys_rst_pulse` is high for exactly RST_CYCLES cycles, starting on the cycle after the strobe. If `rst_enable` is 0, there is no pulse.
- R8: `rec_select` is high for exactly one cycle per expiry. On that cycle, `rec_n_out` and `rec_m_out` take the values of `rec_n_in` and `rec_m_in`, and they hold those values afterwards.
- R9: After expiry, the timer does not fire again until a `kick` or `cfg_write` re-arms it.
- R10: A `kick` that arrives on the same edge as the final step wins: the counter reloads and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_enable | input | 1 | Watchdog enable |
| wd_timeout | input | 5 | Timeout in steps; 0 disables counting |
| wd_coarse | input | 1 | 1 selects 150 ms steps, 0 selects 15 ms steps |
| rst_enable | input | 1 | Allows expiry to drive the reset pulse |
| cfg_write | input | 1 | Strobe for any configuration write; re-arms the timer |
| kick | input | 1 | Explicit refresh; re-arms the timer |
| status_clr | input | 1 | Clears the expiry flag |
| rec_n_in | input | 8 | Programmed recovery N divider |
| rec_m_in | input | 8 | Programmed recovery M divider |
| wd_status | output | 1 | Sticky expiry flag |
| sys_rst_pulse | output | 1 | System reset pulse |
| rec_select | output | 1 | One-cycle request to switch to the recovery frequency |
| rec_n_out | output | 8 | Recovery N value latched at expiry |
| rec_m_out | output | 8 | Recovery M value latched at expiry |

## Verification
The bench targets two collisions. In the first, a kick lands on the edge that would complete the final step. The bench raises `kick` in the last counting cycle and requires no strobe on that edge, followed by a full new timeout. In the second, a status clear lands on the expiry edge. The bench raises `status_clr` in the cycle before the strobe and requires `wd_status` to read 1 after that edge. Random runs also place re-arms at random points in the count, including the final cycle.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FIRE,
        ST_PULSE,
        ST_EXPIRED
    } wdr_state_e;

endpackage

// File: rtl/wdr_tick_gen.sv
module wdr_tick_gen #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_direct
            assign tick = run && !clr;
        end else begin : g_count
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clr) begin
                    cnt_q <= '0;
                end else if (run) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            assign tick = run && !clr && (cnt_q == LAST);

            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/wdr_step_gen.sv
module wdr_step_gen #(
    parameter int unsigned FINE_MS   = 15,
    parameter int unsigned COARSE_MS = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic coarse,
    input  logic tick,
    output logic step
);

    localparam int unsigned MAXMS = (COARSE_MS > FINE_MS) ? COARSE_MS : FINE_MS;
    localparam int unsigned CW    = $clog2(MAXMS + 1);
    localparam logic [CW-1:0] FINE_LAST   = CW'(FINE_MS - 1);
    localparam logic [CW-1:0] COARSE_LAST = CW'(COARSE_MS - 1);

    logic [CW-1:0] lim_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= FINE_LAST;
            cnt_q <= '0;
        end else if (clr) begin
            lim_q <= coarse ? COARSE_LAST : FINE_LAST;
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == lim_q) ? '0 : cnt_q + 1'b1;
        end
    end

    assign step = tick && !clr && (cnt_q == lim_q);

    // R3
    step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);

endmodule

// File: rtl/wdr_fsm.sv
module wdr_fsm
    import wdr_pkg::*;
#(
    parameter int unsigned TO_W       = 5,
    parameter int unsigned N_W        = 8,
    parameter int unsigned M_W        = 8,
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wd_enable,
    input  logic [TO_W-1:0] wd_timeout,
    input  logic            rst_enable,
    input  logic            cfg_write,
    input  logic            kick,
    input  logic            status_clr,
    input  logic [N_W-1:0]  rec_n_in,
    input  logic [M_W-1:0]  rec_m_in,
    input  logic            step,
    output logic            load,
    output logic            run,
    output logic            wd_status,
    output logic            sys_rst_pulse,
    output logic            rec_select,
    output logic [N_W-1:0]  rec_n_out,
    output logic [M_W-1:0]  rec_m_out
);

    localparam int unsigned PW = $clog2(RST_CYCLES + 1);
    localparam logic [PW-1:0] PULSE_LAST = PW'(RST_CYCLES - 1);

    wdr_state_e      state_q, state_d;
    logic [TO_W-1:0] remain_q;
    logic [PW-1:0]   pcnt_q;
    logic            active;
    logic            refresh;
    logic            fire_now;

    assign active  = wd_enable && (wd_timeout != '0);
    assign refresh = kick || cfg_write;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (active) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!active)                                state_d = ST_IDLE;
                else if (refresh)                           state_d = ST_ARMED;
                else if (step && remain_q == TO_W'(1))      state_d = ST_FIRE;
            end
            ST_FIRE: begin
                state_d = rst_enable ? ST_PULSE : ST_EXPIRED;
            end
            ST_PULSE: begin
                if (pcnt_q == '0) state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (!active)      state_d = ST_IDLE;
                else if (refresh) state_d = ST_ARMED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output and control decode
    always_comb begin
        load          = 1'b0;
        run           = 1'b0;
        rec_select    = 1'b0;
        sys_rst_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE:    load = active;
            ST_ARMED: begin
                run  = 1'b1;
                load = active && refresh;
            end
            ST_FIRE:    rec_select = 1'b1;
            ST_PULSE:   sys_rst_pulse = 1'b1;
            ST_EXPIRED: load = active && refresh;
            default: ;
        endcase
    end

    assign fire_now = (state_q == ST_ARMED) && (state_d == ST_FIRE);

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q  <= '0;
            pcnt_q    <= '0;
            wd_status <= 1'b0;
            rec_n_out <= '0;
            rec_m_out <= '0;
        end else begin
            if (load)
                remain_q <= wd_timeout;
            else if (run && step)
                remain_q <= remain_q - 1'b1;

            if (state_q == ST_FIRE)
                pcnt_q <= PULSE_LAST;
            else if (state_q == ST_PULSE && pcnt_q != '0)
                pcnt_q <= pcnt_q - 1'b1;

            if (fire_now)
                wd_status <= 1'b1;
            else if (status_clr)
                wd_status <= 1'b0;

            if (fire_now) begin
                rec_n_out <= rec_n_in;
                rec_m_out <= rec_m_in;
            end
        end
    end

    // R8
    sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_select |=> !rec_select);

    // R8
    sel_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_select |-> wd_status);

    // R6
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_status && !status_clr) |=> wd_status);

    // R7
    rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_select && !rst_enable) |=> !sys_rst_pulse);

    // R7
    rst_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_pulse) |-> $past(rec_select));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_enable |=> !rec_select);

    // R10
    refresh_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && refresh) |=> !rec_select);

endmodule

// File: rtl/wdt_recovery_ctrl.sv
module wdt_recovery_ctrl #(
    parameter int unsigned CLK_PER_MS = 1000,
    parameter int unsigned FINE_MS    = 15,
    parameter int unsigned COARSE_MS  = 150,
    parameter int unsigned TO_W       = 5,
    parameter int unsigned N_W        = 8,
    parameter int unsigned M_W        = 8,
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wd_enable,
    input  logic [TO_W-1:0] wd_timeout,
    input  logic            wd_coarse,
    input  logic            rst_enable,
    input  logic            cfg_write,
    input  logic            kick,
    input  logic            status_clr,
    input  logic [N_W-1:0]  rec_n_in,
    input  logic [M_W-1:0]  rec_m_in,
    output logic            wd_status,
    output logic            sys_rst_pulse,
    output logic            rec_select,
    output logic [N_W-1:0]  rec_n_out,
    output logic [M_W-1:0]  rec_m_out
);

    logic load;
    logic run;
    logic tick;
    logic step;

    wdr_tick_gen #(
        .DIV (CLK_PER_MS)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .run   (run),
        .tick  (tick)
    );

    wdr_step_gen #(
        .FINE_MS   (FINE_MS),
        .COARSE_MS (COARSE_MS)
    ) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (load),
        .coarse (wd_coarse),
        .tick   (tick),
        .step   (step)
    );

    wdr_fsm #(
        .TO_W       (TO_W),
        .N_W        (N_W),
        .M_W        (M_W),
        .RST_CYCLES (RST_CYCLES)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wd_enable     (wd_enable),
        .wd_timeout    (wd_timeout),
        .rst_enable    (rst_enable),
        .cfg_write     (cfg_write),
        .kick          (kick),
        .status_clr    (status_clr),
        .rec_n_in      (rec_n_in),
        .rec_m_in      (rec_m_in),
        .step          (step),
        .load          (load),
        .run           (run),
        .wd_status     (wd_status),
        .sys_rst_pulse (sys_rst_pulse),
        .rec_select    (rec_select),
        .rec_n_out     (rec_n_out),
        .rec_m_out     (rec_m_out)
    );

endmodule

// File: tb/sim_wdt_recovery_ctrl.sv
module sim_wdt_recovery_ctrl;

    localparam int CLK_P  = 10;
    localparam int CPM    = 2;
    localparam int FINE   = 15;
    localparam int COARSE = 150;
    localparam int PULSE  = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_enable = 1'b0;
    logic [4:0] wd_timeout = '0;
    logic       wd_coarse = 1'b0;
    logic       rst_enable = 1'b0;
    logic       cfg_write = 1'b0;
    logic       kick = 1'b0;
    logic       status_clr = 1'b0;
    logic [7:0] rec_n_in = '0;
    logic [7:0] rec_m_in = '0;
    logic       wd_status;
    logic       sys_rst_pulse;
    logic       rec_select;
    logic [7:0] rec_n_out;
    logic [7:0] rec_m_out;

    int checks = 0;
    int fails = 0;
    int sel_seen = 0;
    int rst_seen = 0;
    bit exp_status = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wdt_recovery_ctrl #(
        .CLK_PER_MS (CPM),
        .FINE_MS    (FINE),
        .COARSE_MS  (COARSE),
        .RST_CYCLES (PULSE)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .wd_enable (wd_enable), .wd_timeout (wd_timeout),
        .wd_coarse (wd_coarse), .rst_enable (rst_enable), .cfg_write (cfg_write),
        .kick (kick), .status_clr (status_clr), .rec_n_in (rec_n_in), .rec_m_in (rec_m_in),
        .wd_status (wd_status), .sys_rst_pulse (sys_rst_pulse), .rec_select (rec_select),
        .rec_n_out (rec_n_out), .rec_m_out (rec_m_out)
    );

    // output monitor, a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rec_select)    sel_seen++;
        if (sys_rst_pulse) rst_seen++;
    end

    function automatic int exp_edges(input int t, input bit coarse);
        return t * (coarse ? COARSE : FINE) * CPM;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // rekick: 0 = none, else re-arm pulse in cycle before edge rekick after load
    task automatic run_fire(input int t, input bit coarse, input bit rsten,
                            input logic [7:0] n, input logic [7:0] m,
                            input bit clr_at_fire, input int rekick, input bit use_cfg);
        int k;
        int sel0;
        int rst0;
        k = exp_edges(t, coarse);
        @(negedge clk);
        wd_enable  = 1'b1;
        wd_timeout = 5'(t);
        wd_coarse  = coarse;
        rst_enable = rsten;
        rec_n_in   = n;
        rec_m_in   = m;
        kick       = 1'b1;
        sel0 = sel_seen;
        rst0 = rst_seen;
        @(posedge clk);
        @(negedge clk);
        kick = 1'b0;
        if (rekick > 0) begin
            repeat (rekick - 1) @(posedge clk);
            @(negedge clk);
            if (use_cfg) cfg_write = 1'b1; else kick = 1'b1;
            @(posedge clk);
            @(negedge clk);
            cfg_write = 1'b0;
            kick = 1'b0;
            // R5 R10: re-arm on or before the final step suppresses expiry
            chk("R10", "no strobe on re-arm edge", int'(rec_select), 0);
        end
        repeat (k - 1) @(posedge clk);
        @(negedge clk);
        chk(coarse ? "R2" : "R3", "no strobe one edge early", int'(rec_select), 0);
        chk("R6", "status before expiry (sticky across reload)", int'(wd_status), int'(exp_status));
        if (clr_at_fire) status_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        status_clr = 1'b0;
        chk(coarse ? "R2" : "R3", "strobe at expiry edge", int'(rec_select), 1);
        chk("R6", "status set on expiry", int'(wd_status), 1);
        chk("R8", "rec_n_out", int'(rec_n_out), int'(n));
        chk("R8", "rec_m_out", int'(rec_m_out), int'(m));
        exp_status = 1'b1;
        rec_n_in = ~n;
        rec_m_in = ~m;
        repeat (PULSE + 3) @(negedge clk);
        chk("R8", "single strobe", sel_seen - sel0, 1);
        chk("R7", "reset pulse length", rst_seen - rst0, rsten ? PULSE : 0);
        chk("R8", "rec_n_out held", int'(rec_n_out), int'(n));
        chk("R8", "rec_m_out held", int'(rec_m_out), int'(m));
    endtask

    task automatic clear_status();
        @(negedge clk);
        status_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        status_clr = 1'b0;
        exp_status = 1'b0;
        chk("R6", "status after clear", int'(wd_status), 0);
    endtask

    task automatic quiet_wait(input string req, input int cycles);
        int sel0;
        @(negedge clk);
        kick = 1'b1;
        sel0 = sel_seen;
        @(negedge clk);
        kick = 1'b0;
        repeat (cycles) @(negedge clk);
        chk(req, "no strobe while inactive", sel_seen - sel0, 0);
        chk(req, "status unchanged while inactive", int'(wd_status), int'(exp_status));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk("R1", "status at reset", int'(wd_status), 0);
        chk("R1", "reset out at reset", int'(sys_rst_pulse), 0);
        chk("R1", "strobe at reset", int'(rec_select), 0);
        chk("R1", "rec_n_out at reset", int'(rec_n_out), 0);
        chk("R1", "rec_m_out at reset", int'(rec_m_out), 0);
        rst_n = 1'b1;

        // R2 coarse expiry with reset pulse (R7)
        run_fire(2, 1'b1, 1'b1, 8'h5A, 8'h33, 1'b0, 0, 1'b0);

        // R9: stays expired, no further firing
        begin
            int s0;
            s0 = sel_seen;
            repeat (2000) @(negedge clk);
            chk("R9", "no refire while expired", sel_seen - s0, 0);
        end

        // R3 fine scale, R6 clear coincident with expiry, R7 no pulse
        run_fire(1, 1'b0, 1'b0, 8'hC3, 8'h7E, 1'b1, 0, 1'b0);
        clear_status();
        run_fire(3, 1'b0, 1'b1, 8'h11, 8'h22, 1'b0, 0, 1'b0);
        clear_status();

        // R5 kick mid-count and write mid-count
        run_fire(2, 1'b0, 1'b0, 8'h01, 8'h02, 1'b0, 25, 1'b0);
        run_fire(2, 1'b0, 1'b0, 8'h03, 8'h04, 1'b0, 40, 1'b1);
        clear_status();

        // R10 kick exactly on the final-step edge
        run_fire(1, 1'b0, 1'b1, 8'hAA, 8'h55, 1'b0, exp_edges(1, 1'b0), 1'b0);

        // R4 disabled, and zero timeout
        @(negedge clk);
        wd_enable = 1'b0;
        wd_timeout = 5'd1;
        wd_coarse = 1'b0;
        quiet_wait("R4", exp_edges(31, 1'b0) + 50);
        @(negedge clk);
        wd_enable = 1'b1;
        wd_timeout = 5'd0;
        quiet_wait("R4", exp_edges(31, 1'b0) + 50);

        // random runs
        for (int i = 0; i < 12; i++) begin
            int t;
            bit c;
            int rk;
            t = int'($urandom_range(1, 31));
            c = 1'($urandom_range(0, 1));
            if (c && t > 8) t = t % 8 + 1;
            rk = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, exp_edges(t, c)));
            if ($urandom_range(0, 2) == 0) clear_status();
            run_fire(t, c, 1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom),
                     1'($urandom_range(0, 1)), rk, 1'($urandom_range(0, 1)));
        end

        summary();
        $finish;
    end

endmodule